// File: doc/BRIEF.md
# Rotate and carry-bit logic unit

This block is the execution slice of an 8-bit accumulator processor that performs one-place rotates and single-bit Boolean work through the carry flag. A controller presents an operation code, the accumulator, a 16-bit register pair, an operand byte with a 3-bit bit index and a source class, the status word and the current carry, then pulses `start_i`. After the operation's latency the unit raises `done_o` for one cycle, and its registered outputs then hold the updated accumulator, pair, operand byte, status word and carry.

The carry acts as a one-bit accumulator for the Boolean operations. The selected bit comes from the accumulator, from the status word, or from an operand byte supplied on a port (a direct/special-register byte or a byte reached through the extended-segment pointer). Latency depends on where a bit is written. Every result leaves the status word with its carry position equal to the carry output. Writing the carry into a status-word bit can change the zero or auxiliary-carry flag.

Top module: `rot_bit_unit`

## Requirements
- R1: Op code 0 rotates the accumulator right by one place; old bit 0 goes into bit 7 and into the carry.
- R2: Op code 1 rotates the accumulator left by one place; old bit 7 goes into bit 0 and into the carry.
- R3: Op code 2 rotates the accumulator right through the carry: the new carry is old bit 0 and the new bit 7 is the old carry.
- R4: Op code 3 rotates the accumulator left through the carry: the new carry is old bit 7 and the new bit 0 is the old carry.
- R5: Op code 4 rotates the 16-bit pair left through the carry: the new carry is old bit 15, the new bit 0 is the old carry, and the accumulator is unchanged.
- R6: Op code 5 copies bit `idx_i` of the source byte into the carry. Op code 6 writes the carry into bit `idx_i` of the destination and leaves its other seven bits unchanged. Source class 0 is the accumulator, 1 the status word, 2 a direct/special-register byte, and 3 a byte reached through the extended-segment pointer (classes 2 and 3 use `opnd_i`).
- R7: Op code 7 sets the carry to carry AND the selected bit. Op code 8 sets it to carry OR the selected bit. The operand byte is not modified.
- R8: The carry sits at status bit 0, auxiliary carry at bit 4 and zero at bit 6. Except for op 6 with class 1, every operation leaves status bits 1..7 unchanged and sets bit 0 to the new carry. Op 6 with class 1 writes the carry into the indexed status bit, which may change zero or auxiliary carry. In every case `cy_o` equals `status_o` bit 0.
- R9: Latency from the accepting clock edge to `done_o` is 1 cycle for rotates, carry reads, AND/OR and op 6 into the accumulator. Op 6 takes 2 cycles into class 2, 3 cycles into class 3 and 4 cycles into class 1.
- R10: `done_o` is a one-cycle pulse. A `start_i` arriving while an operation is in progress is ignored. The outputs change only together with `done_o` and otherwise hold.
- R11: Op codes 9 to 15 produce `done_o` after one cycle and leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_i | input | 4 | Operation code |
| src_i | input | 2 | Bit-operand source class |
| idx_i | input | 3 | Bit index within the selected byte |
| acc_i | input | 8 | Accumulator |
| pair_i | input | 16 | Register pair |
| opnd_i | input | 8 | Operand byte (direct or extended-pointer) |
| status_i | input | 8 | Status word |
| cy_i | input | 1 | Current carry |
| acc_o | output | 8 | Updated accumulator |
| pair_o | output | 16 | Updated register pair |
| opnd_o | output | 8 | Updated operand byte |
| status_o | output | 8 | Updated status word |
| cy_o | output | 1 | Updated carry |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each rotate is driven with edge patterns where the moving bit is 1 and the carry is 0, and the reverse, so the plain and through-carry forms cannot be confused and a swapped direction shows up. Bit operations use operands where only the indexed bit differs from its neighbours, so an index off by one or a disturbed neighbour shows. Writes cover every source class, which separates the four latencies, and a status-word write that clears auxiliary carry shows that flags other than the carry can change. A start during a long write and an unsupported code after a known result show that the outputs hold.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int CY_POS = 0;
  localparam int AC_POS = 4;
  localparam int Z_POS  = 6;

  typedef enum logic [3:0] {
    OP_ROR   = 4'd0,
    OP_ROL   = 4'd1,
    OP_RORC  = 4'd2,
    OP_ROLC  = 4'd3,
    OP_ROLWC = 4'd4,
    OP_LDC   = 4'd5,
    OP_STC   = 4'd6,
    OP_ANDC  = 4'd7,
    OP_ORC   = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SRC_ACC  = 2'd0,
    SRC_STAT = 2'd1,
    SRC_DIR  = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;
endpackage

// File: rtl/rbu_rotate.sv
module rbu_rotate
  import rbu_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [PW-1:0] pair_i,
  input  logic          cy_i,
  output logic [DW-1:0] acc_o,
  output logic [PW-1:0] pair_o,
  output logic          cy_o,
  output logic          hit_o
);
  always_comb begin
    acc_o  = acc_i;
    pair_o = pair_i;
    cy_o   = cy_i;
    hit_o  = 1'b1;
    case (op_i)
      OP_ROR:   begin acc_o = {acc_i[0], acc_i[DW-1:1]};    cy_o = acc_i[0];     end
      OP_ROL:   begin acc_o = {acc_i[DW-2:0], acc_i[DW-1]}; cy_o = acc_i[DW-1];  end
      OP_RORC:  begin acc_o = {cy_i, acc_i[DW-1:1]};        cy_o = acc_i[0];     end
      OP_ROLC:  begin acc_o = {acc_i[DW-2:0], cy_i};        cy_o = acc_i[DW-1];  end
      OP_ROLWC: begin pair_o = {pair_i[PW-2:0], cy_i};      cy_o = pair_i[PW-1]; end
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbu_bitop.sv
module rbu_bitop
  import rbu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic [3:0]    op_i,
  input  logic [1:0]    src_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] stat_i,
  input  logic          cy_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] opnd_o,
  output logic [DW-1:0] stat_o,
  output logic          cy_o,
  output logic          hit_o
);
  logic [DW-1:0] src_byte;
  logic [DW-1:0] stat_w;
  logic          sel_bit;
  logic          cy_n;
  logic          stat_dst;

  always_comb begin
    case (src_i)
      SRC_ACC:  src_byte = acc_i;
      SRC_STAT: src_byte = stat_i;
      default:  src_byte = opnd_i;
    endcase
  end

  assign sel_bit  = src_byte[idx_i];
  assign stat_dst = (op_i == OP_STC) && (src_i == SRC_STAT);

  always_comb begin
    acc_o  = acc_i;
    opnd_o = opnd_i;
    stat_w = stat_i;
    cy_n   = cy_i;
    hit_o  = 1'b1;
    case (op_i)
      OP_LDC:  cy_n = sel_bit;
      OP_ANDC: cy_n = cy_i & sel_bit;
      OP_ORC:  cy_n = cy_i | sel_bit;
      OP_STC: begin
        case (src_i)
          SRC_ACC:  acc_o[idx_i]  = cy_i;
          SRC_STAT: stat_w[idx_i] = cy_i;
          default:  opnd_o[idx_i] = cy_i;
        endcase
      end
      default: hit_o = 1'b0;
    endcase
  end

  // status-bit write defines the carry; otherwise carry is mirrored into the word
  always_comb begin
    if (stat_dst) begin
      stat_o = stat_w;
      cy_o   = stat_w[CY_POS];
    end else begin
      stat_o         = stat_i;
      stat_o[CY_POS] = cy_n;
      cy_o           = cy_n;
    end
  end
endmodule

// File: rtl/rbu_seq.sv
module rbu_seq
  import rbu_pkg::*;
#(
  parameter int LAT_ACC  = 1,
  parameter int LAT_DIR  = 2,
  parameter int LAT_EXT  = 3,
  parameter int LAT_STAT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [3:0] op_i,
  input  logic [1:0] src_i,
  output logic       accept_o,
  output logic       commit_o,
  output logic       busy_o
);
  localparam int LAT_M1  = (LAT_ACC > LAT_DIR) ? LAT_ACC : LAT_DIR;
  localparam int LAT_M2  = (LAT_EXT > LAT_STAT) ? LAT_EXT : LAT_STAT;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CW      = $clog2(LAT_MAX + 1);

  logic [CW-1:0] lat;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_comb begin
    lat = CW'(1);
    if (op_i == OP_STC) begin
      case (src_i)
        SRC_ACC:  lat = CW'(LAT_ACC);
        SRC_STAT: lat = CW'(LAT_STAT);
        SRC_DIR:  lat = CW'(LAT_DIR);
        default:  lat = CW'(LAT_EXT);
      endcase
    end
  end

  assign accept_o = start_i && !busy_q;
  assign commit_o = (accept_o && lat <= CW'(1)) || (busy_q && cnt_q == CW'(1));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o && lat > CW'(1)) begin
      busy_q <= 1'b1;
      cnt_q  <= lat - CW'(1);
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  // R10: counter never wraps while busy
  a_r10_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
endmodule

// File: rtl/rot_bit_unit.sv
module rot_bit_unit
  import rbu_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PW       = 16,
  parameter int IW       = $clog2(DW),
  parameter int LAT_ACC  = 1,
  parameter int LAT_DIR  = 2,
  parameter int LAT_EXT  = 3,
  parameter int LAT_STAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    src_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] acc_i,
  input  logic [PW-1:0] pair_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] status_i,
  input  logic          cy_i,
  output logic [DW-1:0] acc_o,
  output logic [PW-1:0] pair_o,
  output logic [DW-1:0] opnd_o,
  output logic [DW-1:0] status_o,
  output logic          cy_o,
  output logic          done_o
);
  logic [DW-1:0] r_acc;
  logic [PW-1:0] r_pair;
  logic          r_cy, r_hit;
  logic [DW-1:0] b_acc, b_opnd, b_stat;
  logic          b_cy, b_hit;
  logic          accept_w, commit_w, busy_w;

  logic [DW-1:0] c_acc, c_opnd, c_stat;
  logic [PW-1:0] c_pair;
  logic          c_cy, c_valid;

  logic [DW-1:0] p_acc, p_opnd, p_stat;
  logic [PW-1:0] p_pair;
  logic          p_cy, p_valid;

  logic [DW-1:0] n_acc, n_opnd, n_stat;
  logic [PW-1:0] n_pair;
  logic          n_cy, n_valid;

  rbu_rotate #(.DW(DW), .PW(PW)) u_rot (
    .op_i  (op_i),
    .acc_i (acc_i),
    .pair_i(pair_i),
    .cy_i  (cy_i),
    .acc_o (r_acc),
    .pair_o(r_pair),
    .cy_o  (r_cy),
    .hit_o (r_hit)
  );

  rbu_bitop #(.DW(DW), .IW(IW)) u_bit (
    .op_i  (op_i),
    .src_i (src_i),
    .idx_i (idx_i),
    .acc_i (acc_i),
    .opnd_i(opnd_i),
    .stat_i(status_i),
    .cy_i  (cy_i),
    .acc_o (b_acc),
    .opnd_o(b_opnd),
    .stat_o(b_stat),
    .cy_o  (b_cy),
    .hit_o (b_hit)
  );

  rbu_seq #(
    .LAT_ACC(LAT_ACC), .LAT_DIR(LAT_DIR), .LAT_EXT(LAT_EXT), .LAT_STAT(LAT_STAT)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .src_i   (src_i),
    .accept_o(accept_w),
    .commit_o(commit_w),
    .busy_o  (busy_w)
  );

  always_comb begin
    c_valid = r_hit | b_hit;
    if (r_hit) begin
      c_acc          = r_acc;
      c_pair         = r_pair;
      c_opnd         = opnd_i;
      c_stat         = status_i;
      c_stat[CY_POS] = r_cy;
      c_cy           = r_cy;
    end else begin
      c_acc  = b_acc;
      c_pair = pair_i;
      c_opnd = b_opnd;
      c_stat = b_stat;
      c_cy   = b_cy;
    end
  end

  // a one-cycle result commits straight from the datapath, longer ones from the hold stage
  always_comb begin
    if (accept_w) begin
      n_acc = c_acc; n_pair = c_pair; n_opnd = c_opnd;
      n_stat = c_stat; n_cy = c_cy; n_valid = c_valid;
    end else begin
      n_acc = p_acc; n_pair = p_pair; n_opnd = p_opnd;
      n_stat = p_stat; n_cy = p_cy; n_valid = p_valid;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_acc <= '0; p_pair <= '0; p_opnd <= '0;
      p_stat <= '0; p_cy <= 1'b0; p_valid <= 1'b0;
    end else if (accept_w) begin
      p_acc <= c_acc; p_pair <= c_pair; p_opnd <= c_opnd;
      p_stat <= c_stat; p_cy <= c_cy; p_valid <= c_valid;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0; pair_o <= '0; opnd_o <= '0;
      status_o <= '0; cy_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= commit_w;
      if (commit_w && n_valid) begin
        acc_o <= n_acc; pair_o <= n_pair; opnd_o <= n_opnd;
        status_o <= n_stat; cy_o <= n_cy;
      end
    end
  end

  a_r1_ror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && op_i == OP_ROR) |=>
      (acc_o == {$past(acc_i[0]), $past(acc_i[DW-1:1])} && cy_o == $past(acc_i[0])));

  a_r5_rolwc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && op_i == OP_ROLWC) |=>
      (pair_o == {$past(pair_i[PW-2:0]), $past(cy_i)} && acc_o == $past(acc_i)));

  a_r7_and_keeps_opnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && op_i == OP_ANDC) |=> opnd_o == $past(opnd_i));

  a_r8_cy_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cy_o == status_o[CY_POS]);

  a_r10_change_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({acc_o, pair_o, opnd_o, status_o, cy_o}) |-> done_o);

  a_r10_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && !commit_w) |=> !done_o);

  a_r11_unsup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && !c_valid) |=> (done_o && $stable({acc_o, pair_o, opnd_o, status_o, cy_o})));
endmodule

// File: tb/sim_rot_bit_unit.sv
module sim_rot_bit_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  src = '0;
  logic [2:0]  idx = '0;
  logic [7:0]  acc = '0, opnd = '0, stat = '0;
  logic [15:0] pair = '0;
  logic        cy = 1'b0;
  logic [7:0]  acc_o, opnd_o, stat_o;
  logic [15:0] pair_o;
  logic        cy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  int lat;

  always #4 clk = ~clk;

  rot_bit_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .src_i(src),
    .idx_i(idx), .acc_i(acc), .pair_i(pair), .opnd_i(opnd), .status_i(stat),
    .cy_i(cy), .acc_o(acc_o), .pair_o(pair_o), .opnd_o(opnd_o),
    .status_o(stat_o), .cy_o(cy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [1:0] s, input logic [2:0] i,
                       input logic [7:0] a, input logic [15:0] p, input logic [7:0] d,
                       input logic [7:0] st, input logic c);
    op = o; src = s; idx = i; acc = a; pair = p; opnd = d; stat = st; cy = c;
  endtask

  // pulse start, count negedges until done
  task automatic run(output int l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    l = 1;
    while (!done_o && l < 20) begin
      @(negedge clk);
      l++;
    end
  endtask

  task automatic t_reset();
    chk("R10 reset done", {31'd0, done_o}, 0);
    chk("R8 reset outputs", {acc_o, opnd_o, stat_o, 7'd0, cy_o}, 0);
  endtask

  task automatic t_ror();
    drive(0, 0, 0, 8'hA5, 16'h1234, 8'h00, 8'h50, 1'b0); run(lat);
    chk("R1 ror acc", acc_o, 8'hD2); chk("R1 ror cy", cy_o, 1);
    chk("R8 ror status", stat_o, 8'h51); chk("R9 ror latency", lat, 1);
    drive(0, 0, 0, 8'h02, 16'h1234, 8'h00, 8'h41, 1'b1); run(lat);
    chk("R1 ror acc2", acc_o, 8'h01); chk("R1 ror cy2", cy_o, 0);
    chk("R8 ror status2", stat_o, 8'h40);
  endtask

  task automatic t_rol();
    drive(1, 0, 0, 8'h81, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R2 rol acc", acc_o, 8'h03); chk("R2 rol cy", cy_o, 1);
    drive(1, 0, 0, 8'h40, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R2 rol acc2", acc_o, 8'h80); chk("R2 rol cy2", cy_o, 0);
  endtask

  task automatic t_rorc();
    drive(2, 0, 0, 8'h01, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R3 rorc acc", acc_o, 8'h00); chk("R3 rorc cy", cy_o, 1);
    drive(2, 0, 0, 8'h80, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R3 rorc acc2", acc_o, 8'hC0); chk("R3 rorc cy2", cy_o, 0);
  endtask

  task automatic t_rolc();
    drive(3, 0, 0, 8'h80, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R4 rolc acc", acc_o, 8'h00); chk("R4 rolc cy", cy_o, 1);
    drive(3, 0, 0, 8'h01, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R4 rolc acc2", acc_o, 8'h03); chk("R4 rolc cy2", cy_o, 0);
  endtask

  task automatic t_rolwc();
    drive(4, 0, 0, 8'h5A, 16'h8001, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R5 pair", pair_o, 16'h0002); chk("R5 cy", cy_o, 1);
    chk("R5 acc kept", acc_o, 8'h5A); chk("R9 pair latency", lat, 1);
    drive(4, 0, 0, 8'h5A, 16'h4000, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R5 pair2", pair_o, 16'h8001); chk("R5 cy2", cy_o, 0);
  endtask

  task automatic t_move();
    drive(5, 0, 7, 8'h80, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R6 read acc bit", cy_o, 1); chk("R9 read latency", lat, 1);
    drive(5, 2, 0, 8'h00, 16'h0, 8'hFE, 8'h01, 1'b1); run(lat);
    chk("R6 read opnd bit", cy_o, 0); chk("R6 read opnd kept", opnd_o, 8'hFE);
    drive(5, 1, 6, 8'h00, 16'h0, 8'h00, 8'h40, 1'b0); run(lat);
    chk("R6 read status bit", cy_o, 1); chk("R8 read status word", stat_o, 8'h41);
    drive(6, 0, 3, 8'h00, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R6 write acc", acc_o, 8'h08); chk("R9 write acc latency", lat, 1);
    drive(6, 2, 5, 8'h00, 16'h0, 8'hFF, 8'h00, 1'b0); run(lat);
    chk("R6 write direct", opnd_o, 8'hDF); chk("R9 write direct latency", lat, 2);
    drive(6, 3, 7, 8'h00, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R6 write ext", opnd_o, 8'h80); chk("R9 write ext latency", lat, 3);
    drive(6, 1, 6, 8'h00, 16'h0, 8'h00, 8'h01, 1'b1); run(lat);
    chk("R8 write status z", stat_o, 8'h41); chk("R9 write status latency", lat, 4);
    chk("R8 write status cy", cy_o, 1);
    drive(6, 1, 4, 8'h00, 16'h0, 8'h00, 8'h50, 1'b0); run(lat);
    chk("R8 write status ac", stat_o, 8'h40); chk("R8 write status cy2", cy_o, 0);
  endtask

  task automatic t_andor();
    drive(7, 2, 2, 8'h00, 16'h0, 8'h04, 8'h01, 1'b1); run(lat);
    chk("R7 and true", cy_o, 1); chk("R7 and opnd kept", opnd_o, 8'h04);
    drive(7, 2, 3, 8'h00, 16'h0, 8'h04, 8'h01, 1'b1); run(lat);
    chk("R7 and false", cy_o, 0);
    drive(8, 0, 4, 8'h10, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R7 or true", cy_o, 1); chk("R7 or acc kept", acc_o, 8'h10);
    drive(8, 0, 0, 8'h10, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    chk("R7 or false", cy_o, 0); chk("R9 or latency", lat, 1);
  endtask

  task automatic t_ignored();
    int l;
    drive(6, 1, 6, 8'h33, 16'h0, 8'h00, 8'h01, 1'b1);
    start = 1'b1;
    @(negedge clk);
    drive(0, 0, 0, 8'hFF, 16'hFFFF, 8'hAA, 8'h00, 1'b0);
    @(negedge clk);
    start = 1'b0;
    l = 2;
    while (!done_o && l < 20) begin
      @(negedge clk);
      l++;
    end
    chk("R10 late start ignored latency", l, 4);
    chk("R10 late start ignored acc", acc_o, 8'h33);
    chk("R10 late start ignored status", stat_o, 8'h41);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done_o}, 0);
    chk("R10 outputs hold", {acc_o, stat_o}, {8'h33, 8'h41});
  endtask

  task automatic t_unsup();
    drive(0, 0, 0, 8'h01, 16'h0, 8'h00, 8'h00, 1'b0); run(lat);
    drive(4'hF, 2, 1, 8'h7E, 16'hBEEF, 8'h55, 8'h50, 1'b0); run(lat);
    chk("R11 unsupported latency", lat, 1);
    chk("R11 unsupported acc", acc_o, 8'h80);
    chk("R11 unsupported cy", cy_o, 1);
    chk("R11 unsupported status", stat_o, 8'h01);
    chk("R11 unsupported opnd", opnd_o, 8'h00);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ror();
    t_rol();
    t_rorc();
    t_rolc();
    t_rolwc();
    t_move();
    t_andor();
    t_ignored();
    t_unsup();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule